// File: doc/BRIEF.md
# Adaptive Window Sequential Prefetcher

This block watches demand references to cache blocks, each marked as a hit or a miss. When a reference triggers it, the block takes the referenced block address as a base. It then issues the next `win` block addresses, base+1 up to base+win, as prefetch requests over a valid/ready handshake. After issuing, it listens to the following references and scores how many of them land on blocks it just prefetched. At the end of that listening phase it shrinks, keeps or grows `win`.

The score is compared with a configured threshold. A failing window shrinks `win` by one. A window that passes increments a lock counter. Only after a configured number of consecutive passes does `win` grow by one, and it stops growing at a ceiling.

A mode input picks when the next window starts:
- Aggressive: the next window starts straight after the last listened reference.
- Miss-restart: after the window the block waits for the next miss.
- Discard-on-miss: only hits are listened to, and any miss cuts the window short and restarts at once.

Top module: `seq_prefetch_adapt`

## Requirements
- R1: The first miss after reset triggers a window. A trigger at block address B makes the block issue B+1, B+2, … B+win in increasing order, one address per accepted handshake. When a window's issue is done, `pf_valid` is low until the next trigger.
- R2: While `pf_valid` is high and `pf_ready` is low, `pf_valid` stays high and `pf_addr` does not change. No address is skipped.
- R3: The listening phase begins after the issue phase has drained. A reference counts as good when its address is strictly above B and at most B+win. References presented during the issue phase are ignored. No prefetch is issued while the block listens or waits.
- R4: A finished window whose good count is below `cfg_thresh` reduces `win` by one, but never below 1. It also clears the lock counter.
- R5: A finished window whose good count is at least `cfg_thresh` increments the lock counter. When the counter reaches `cfg_lock` (0 is treated as 1), `win` grows by one and the counter clears. Otherwise `win` is kept.
- R6: `win` never exceeds the parameter MAX_WIN (default 12). Between windows it changes by at most one.
- R7: In mode 0 (aggressive; code 3 behaves the same), every reference counts toward the window length. The reference that completes the window is also the trigger of the next window, whether it hit or missed.
- R8: In mode 1 (miss-restart), every reference counts toward the length. After the window completes, hits are ignored and the next miss is the trigger.
- R9: In mode 2 (discard-on-miss), only hits count toward the length. A miss while listening ends the window, scores it with the hits counted so far, and triggers a new window at the miss address. After `win` hits the block waits for a miss.
- R10: A prefetch address that would pass the top of the address space is never issued. A trigger at the all-ones address issues nothing.
- R11: Reset leaves `pf_valid` low, and before the first trigger hits are ignored. The first window's size is `cfg_init_win` clamped into 1..MAX_WIN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_valid | input | 1 | A demand reference is present this cycle |
| ref_addr | input | ADDR_W | Block address of the reference |
| ref_hit | input | 1 | 1 = cache hit, 0 = miss |
| mode | input | 2 | Restart policy: 0 aggressive, 1 miss-restart, 2 discard-on-miss, 3 as 0 |
| cfg_init_win | input | WIN_W | Window size used for the first window |
| cfg_thresh | input | WIN_W | Good references needed for a window to pass |
| cfg_lock | input | LOCK_W | Passing windows needed before growth |
| pf_valid | output | 1 | Prefetch request valid |
| pf_ready | input | 1 | Request queue accepts the request |
| pf_addr | output | ADDR_W | Block address to prefetch |

## Verification
The bench runs long sequential hit runs, which must walk the window up to the ceiling in steps held by the lock count. A design without saturation would go on issuing 13 or more requests per window. Scattered misses and far addresses must shrink the window down to one and no further; an off-by-one in the good-address range would move the pass/fail outcome and the window length would drift from the model. A miss presented while the issue is stalled must be dropped, or every later window length would shift. Triggers just below and at the top address must issue only the blocks that fit, never wrapped addresses. The bench also exercises a zero or oversized initial window, and hits arriving while the block waits in the miss-driven modes, which must not start a window.

// File: rtl/spf_pkg.sv
// Shared types for the adaptive sequential prefetcher.
package spf_pkg;

    // Restart policy codes presented on the mode input.
    typedef enum logic [1:0] {
        MODE_AGGR = 2'd0,
        MODE_MISS = 2'd1,
        MODE_DISC = 2'd2,
        MODE_RSVD = 2'd3
    } spf_mode_e;

    // Control phases of the prefetcher.
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ISSUE  = 2'd1,
        ST_LISTEN = 2'd2,
        ST_WAIT   = 2'd3
    } spf_state_e;

endpackage

// File: rtl/spf_issuer.sv
// Issue sequencer: on start, emits base+1 .. base+win one per accepted handshake.
// Stops early at the top of the address space. Assumes win is stable while
// active and that start is only pulsed when the sequencer is idle.
module spf_issuer #(
    parameter int ADDR_W = 16,
    parameter int WIN_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_base,
    input  logic [WIN_W-1:0]  win,
    input  logic              pf_ready,
    output logic              pf_valid,
    output logic [ADDR_W-1:0] pf_addr
);
    localparam int EXT_W = ADDR_W + 1;

    logic              active_q;
    logic [ADDR_W-1:0] base_q;
    logic [WIN_W-1:0]  off_q;
    logic [EXT_W-1:0]  cur_ext;
    logic [EXT_W-1:0]  nxt_ext;

    // Current and following candidate address, one bit wider to see overflow.
    always_comb begin
        cur_ext = {1'b0, base_q} + EXT_W'(off_q);
        nxt_ext = cur_ext + EXT_W'(1);
    end

    assign pf_valid = active_q;
    assign pf_addr  = cur_ext[ADDR_W-1:0];

    // Advance the offset on each accepted request; finish at win or at the top.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            base_q   <= '0;
            off_q    <= '0;
        end else if (start) begin
            base_q   <= start_base;
            off_q    <= WIN_W'(1);
            active_q <= (start_base != '1);
        end else if (active_q && pf_ready) begin
            if ((off_q >= win) || nxt_ext[ADDR_W]) begin
                active_q <= 1'b0;
            end else begin
                off_q <= off_q + WIN_W'(1);
            end
        end
    end
endmodule

// File: rtl/spf_window.sv
// Window scorer: holds the window size and lock counter and applies the
// shrink / hold / grow rule on each evaluation. While load is high the window
// follows the clamped initial value.
module spf_window #(
    parameter int MAX_WIN = 12,
    parameter int WIN_W   = 4,
    parameter int LOCK_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WIN_W-1:0]  init_win,
    input  logic              eval,
    input  logic              pass,
    input  logic [LOCK_W-1:0] lock_lim,
    output logic [WIN_W-1:0]  win
);
    localparam logic [WIN_W-1:0] WMAX = WIN_W'(MAX_WIN);

    logic [WIN_W-1:0]  win_q;
    logic [LOCK_W-1:0] lock_q;
    logic [WIN_W-1:0]  init_clamped;
    logic [LOCK_W:0]   lock_inc;
    logic [LOCK_W:0]   lim_eff;

    // Clamp the configured start size and normalise a zero lock limit.
    always_comb begin
        if (init_win == '0)       init_clamped = WIN_W'(1);
        else if (init_win > WMAX) init_clamped = WMAX;
        else                      init_clamped = init_win;
        lock_inc = {1'b0, lock_q} + (LOCK_W+1)'(1);
        lim_eff  = (lock_lim == '0) ? (LOCK_W+1)'(1) : {1'b0, lock_lim};
    end

    assign win = win_q;

    // Apply the adaptation rule at the end of each listening phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q  <= WIN_W'(1);
            lock_q <= '0;
        end else if (load) begin
            win_q  <= init_clamped;
            lock_q <= '0;
        end else if (eval) begin
            if (pass) begin
                if (lock_inc >= lim_eff) begin
                    lock_q <= '0;
                    if (win_q < WMAX) win_q <= win_q + WIN_W'(1);
                end else begin
                    lock_q <= lock_inc[LOCK_W-1:0];
                end
            end else begin
                lock_q <= '0;
                if (win_q > WIN_W'(1)) win_q <= win_q - WIN_W'(1);
            end
        end
    end
endmodule

// File: rtl/seq_prefetch_adapt.sv
// Adaptive window sequential prefetcher top. Tracks issue / listen / wait
// phases, scores references against the last window and selects the restart
// policy from the mode input. Assumes one reference per cycle at most.
module seq_prefetch_adapt #(
    parameter int ADDR_W  = 16,
    parameter int MAX_WIN = 12,
    parameter int LOCK_W  = 4,
    parameter int WIN_W   = $clog2(MAX_WIN + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_valid,
    input  logic [ADDR_W-1:0] ref_addr,
    input  logic              ref_hit,
    input  logic [1:0]        mode,
    input  logic [WIN_W-1:0]  cfg_init_win,
    input  logic [WIN_W-1:0]  cfg_thresh,
    input  logic [LOCK_W-1:0] cfg_lock,
    output logic              pf_valid,
    input  logic              pf_ready,
    output logic [ADDR_W-1:0] pf_addr
);
    import spf_pkg::*;

    localparam int EXT_W = ADDR_W + 1;

    spf_state_e        st_q;
    logic [ADDR_W-1:0] base_q;
    logic [WIN_W-1:0]  seen_q;
    logic [WIN_W-1:0]  good_q;
    logic [WIN_W-1:0]  cur_win;

    logic       listen_ev, in_win, disc_abort, relevant;
    logic       eval, pass, restart, to_wait;
    logic [WIN_W-1:0] seen_nx, good_nx, score;
    logic [EXT_W-1:0] top_ext;

    // Classify the current reference against the window and mode.
    always_comb begin
        top_ext    = {1'b0, base_q} + EXT_W'(cur_win);
        in_win     = (ref_addr > base_q) && ({1'b0, ref_addr} <= top_ext);
        listen_ev  = (st_q == ST_LISTEN) && ref_valid;
        disc_abort = (spf_mode_e'(mode) == MODE_DISC) && !ref_hit;
        relevant   = (spf_mode_e'(mode) == MODE_DISC) ? ref_hit : 1'b1;
        seen_nx    = seen_q + WIN_W'(1);
        good_nx    = good_q + WIN_W'(in_win);
        eval       = listen_ev && (disc_abort || (relevant && (seen_nx == cur_win)));
        score      = disc_abort ? good_q : good_nx;
        pass       = score >= cfg_thresh;
    end

    // Decide whether this reference starts a window or parks the block.
    always_comb begin
        restart = 1'b0;
        to_wait = 1'b0;
        if ((st_q == ST_IDLE || st_q == ST_WAIT) && ref_valid && !ref_hit) begin
            restart = 1'b1;
        end else if (eval) begin
            if (disc_abort || spf_mode_e'(mode) == MODE_AGGR ||
                spf_mode_e'(mode) == MODE_RSVD) begin
                restart = 1'b1;
            end else begin
                to_wait = 1'b1;
            end
        end
    end

    // Phase register, window base and listening counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            base_q <= '0;
            seen_q <= '0;
            good_q <= '0;
        end else if (restart) begin
            st_q   <= ST_ISSUE;
            base_q <= ref_addr;
            seen_q <= '0;
            good_q <= '0;
        end else if (to_wait) begin
            st_q <= ST_WAIT;
        end else if (st_q == ST_ISSUE && !pf_valid) begin
            st_q <= ST_LISTEN;
        end else if (listen_ev && relevant) begin
            seen_q <= seen_nx;
            good_q <= good_nx;
        end
    end

    spf_window #(
        .MAX_WIN (MAX_WIN),
        .WIN_W   (WIN_W),
        .LOCK_W  (LOCK_W)
    ) u_window (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (st_q == ST_IDLE),
        .init_win (cfg_init_win),
        .eval     (eval),
        .pass     (pass),
        .lock_lim (cfg_lock),
        .win      (cur_win)
    );

    spf_issuer #(
        .ADDR_W (ADDR_W),
        .WIN_W  (WIN_W)
    ) u_issuer (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (restart),
        .start_base (ref_addr),
        .win        (cur_win),
        .pf_ready   (pf_ready),
        .pf_valid   (pf_valid),
        .pf_addr    (pf_addr)
    );
endmodule

// File: rtl/spf_checker.sv
// Property checker for the adaptive prefetcher, bound to the top module.
module spf_checker #(
    parameter int ADDR_W  = 16,
    parameter int MAX_WIN = 12,
    parameter int WIN_W   = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pf_valid,
    input logic              pf_ready,
    input logic [ADDR_W-1:0] pf_addr,
    input logic [WIN_W-1:0]  win,
    input logic [1:0]        st
);
    // R2
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid && !pf_ready |=> pf_valid && $stable(pf_addr));

    // R1
    contig_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid && pf_ready |=> !pf_valid || (pf_addr == $past(pf_addr) + 1'b1));

    // R10
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid |-> pf_addr != '0);

    // R6
    win_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win >= WIN_W'(1)) && (win <= WIN_W'(MAX_WIN)));

    // R6
    win_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st != spf_pkg::ST_IDLE |=> (win == $past(win)) ||
            (win == $past(win) + 1'b1) || (win == $past(win) - 1'b1));

    // R3
    quiet_listen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == spf_pkg::ST_LISTEN || st == spf_pkg::ST_WAIT) |-> !pf_valid);
endmodule

bind seq_prefetch_adapt spf_checker #(
    .ADDR_W  (ADDR_W),
    .MAX_WIN (MAX_WIN),
    .WIN_W   (WIN_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pf_valid (pf_valid),
    .pf_ready (pf_ready),
    .pf_addr  (pf_addr),
    .win      (cur_win),
    .st       (st_q)
);

// File: tb/seq_prefetch_adapt_test.sv
`timescale 1ns/1ps
// Bench: directed corners plus seeded random reference streams, compared with
// a behavioural model of the window rules.
module seq_prefetch_adapt_test;
    localparam int AW = 16, MAXW = 12, LW = 4, WW = 4;
    localparam int TOPA = 65535;

    logic clk = 1'b0, rst_n = 1'b0;
    logic ref_valid = 1'b0, ref_hit = 1'b0, pf_ready = 1'b1;
    logic [AW-1:0] ref_addr = '0;
    logic [1:0] mode = 2'd0;
    logic [WW-1:0] cfg_init_win = 4'd4, cfg_thresh = 4'd2;
    logic [LW-1:0] cfg_lock = 4'd1;
    logic pf_valid;
    logic [AW-1:0] pf_addr;

    int total = 0, bad = 0, cyc = 0;
    int m_win, m_lock, m_seen, m_good, m_base, m_state, last_a;
    int c_mode, c_init, c_thr, c_lk;

    seq_prefetch_adapt uut (
        .clk(clk), .rst_n(rst_n), .ref_valid(ref_valid), .ref_addr(ref_addr),
        .ref_hit(ref_hit), .mode(mode), .cfg_init_win(cfg_init_win),
        .cfg_thresh(cfg_thresh), .cfg_lock(cfg_lock), .pf_valid(pf_valid),
        .pf_ready(pf_ready), .pf_addr(pf_addr)
    );

    always #2.5 clk = ~clk;

    // Watchdog: a hung run is a failed check and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            bad++; total++;
            $display("FAIL watchdog: act=%0d exp<=%0d cycles", cyc, 150000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    function automatic int clampw(input int v);
        if (v < 1) return 1;
        if (v > MAXW) return MAXW;
        return v;
    endfunction

    function automatic string mtag();
        if (c_mode == 1) return "R8";
        if (c_mode == 2) return "R9";
        return "R7";
    endfunction

    function automatic void evaluate(input int g);
        int lim = (c_lk == 0) ? 1 : c_lk;
        if (g >= c_thr) begin
            m_lock++;
            if (m_lock >= lim) begin
                m_lock = 0;
                if (m_win < MAXW) m_win++;
            end
        end else begin
            m_lock = 0;
            if (m_win > 1) m_win--;
        end
    endfunction

    // Model one listened reference; returns 1 when a new window starts.
    function automatic bit model_ref(input int a, input bit h);
        bit trig = 0;
        bit good;
        if (m_state != 1) begin
            if (!h) begin
                if (m_state == 0) m_win = clampw(c_init);
                trig = 1;
            end
        end else begin
            good = (a > m_base) && (a <= m_base + m_win);
            if (c_mode == 2 && !h) begin
                evaluate(m_good);
                trig = 1;
            end else begin
                m_seen++;
                if (good) m_good++;
                if (m_seen == m_win) begin
                    evaluate(m_good);
                    if (c_mode == 1 || c_mode == 2) m_state = 2;
                    else trig = 1;
                end
            end
        end
        if (trig) begin
            m_base = a; m_state = 1; m_seen = 0; m_good = 0;
        end
        return trig;
    endfunction

    // Collect one window of prefetches (entered at the negedge after trigger).
    task automatic collect(input string tag, input bit stall);
        int exp_n = (m_win < TOPA - m_base) ? m_win : TOPA - m_base;
        int k = 1;
        int wd = 0;
        bit hs, stalled = 0;
        while (k <= exp_n && wd < 2000) begin
            chk(pf_valid, tag, pf_valid, 1);
            chk(int'(pf_addr) == m_base + k, stalled ? "R2" : "R1", pf_addr, m_base + k);
            pf_ready = stall ? ($urandom % 3 != 0) : 1'b1;
            hs = pf_valid && pf_ready;
            stalled = !pf_ready;
            @(posedge clk); @(negedge clk);
            if (hs) k++;
            wd++;
        end
        pf_ready = 1'b1;
        // window length: no request beyond the expected count
        chk(!pf_valid, tag, pf_valid, 0);
        @(posedge clk); @(negedge clk);
    endtask

    // Present one reference at a negedge and check the reaction.
    task automatic drive_ref(input int a, input bit h, input bit probe);
        int prev_w = m_win;
        int prev_s = m_state;
        bit trig;
        string tag;
        ref_valid = 1'b1; ref_addr = AW'(a); ref_hit = h;
        @(posedge clk); @(negedge clk);
        ref_valid = 1'b0;
        last_a = a;
        trig = model_ref(a, h);
        if (!trig) begin
            chk(!pf_valid, (prev_s == 0) ? "R11" : mtag(), pf_valid, 0);
            return;
        end
        if (m_base + 1 > TOPA || m_base + m_win > TOPA) tag = "R10";
        else if (prev_s == 0) tag = "R11";
        else if (m_win < prev_w) tag = "R4";
        else if (m_win > prev_w) tag = "R5";
        else if (m_win == MAXW) tag = "R6";
        else tag = mtag();
        if (probe && m_base < TOPA) begin
            // R3: a miss during a stalled issue must be ignored; R2: hold
            pf_ready = 1'b0;
            ref_valid = 1'b1; ref_addr = AW'(m_base + 3000); ref_hit = 1'b0;
            @(posedge clk); @(negedge clk);
            ref_valid = 1'b0;
            chk(pf_valid && int'(pf_addr) == m_base + 1, "R2", pf_addr, m_base + 1);
            pf_ready = 1'b1;
            tag = "R3";
        end
        collect(tag, 1'b1);
    endtask

    task automatic do_reset(input int md, input int iw, input int th, input int lk);
        c_mode = md; c_init = iw; c_thr = th; c_lk = lk;
        mode = 2'(md); cfg_init_win = WW'(iw); cfg_thresh = WW'(th); cfg_lock = LW'(lk);
        rst_n = 1'b0; ref_valid = 1'b0; pf_ready = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_state = 0; m_win = clampw(iw); m_lock = 0; m_seen = 0; m_good = 0;
        // R11: nothing issued out of reset
        chk(!pf_valid, "R11", pf_valid, 0);
    endtask

    task automatic run_seq(input int n);
        for (int i = 0; i < n; i++) drive_ref(last_a + 1, 1'b1, 1'b0);
    endtask

    task automatic run_random(input int n);
        for (int i = 0; i < n; i++) begin
            int r = $urandom % 5;
            if (r < 2)       drive_ref(last_a + 1, 1'b1, 1'b0);
            else if (r == 2) drive_ref(last_a + 1, 1'b0, 1'b0);
            else             drive_ref(1000 + ($urandom % 16000), 1'($urandom % 2), 1'b0);
        end
    endtask

    task automatic run_far(input int n);
        for (int i = 0; i < n; i++) drive_ref(20000 + ($urandom % 20000), 1'b1, 1'b0);
    endtask

    initial begin
        void'($urandom(32'd4242));
        // R7: aggressive growth to the ceiling, then shrink to the floor
        do_reset(0, 4, 3, 2);
        drive_ref(50, 1'b1, 1'b0);
        drive_ref(100, 1'b0, 1'b0);
        run_seq(200);
        run_far(60);
        run_random(150);
        // R3: reference during a stalled issue phase
        do_reset(0, 5, 2, 1);
        drive_ref(200, 1'b0, 1'b1);
        run_seq(30);
        // R8: miss-restart policy
        do_reset(1, 3, 2, 1);
        drive_ref(300, 1'b0, 1'b0);
        run_random(250);
        // R9: discard-on-miss policy
        do_reset(2, 5, 2, 3);
        drive_ref(400, 1'b0, 1'b0);
        run_random(300);
        run_seq(80);
        // R7: reserved code behaves as aggressive
        do_reset(3, 2, 1, 1);
        drive_ref(500, 1'b0, 1'b0);
        run_random(60);
        // R10: trigger near and at the top address
        do_reset(0, 6, 1, 1);
        drive_ref(TOPA - 4, 1'b0, 1'b0);
        do_reset(0, 6, 1, 1);
        drive_ref(TOPA, 1'b0, 1'b0);
        run_far(8);
        // R11: initial window clamp
        do_reset(0, 0, 1, 1);
        drive_ref(700, 1'b0, 1'b0);
        do_reset(0, 15, 1, 1);
        drive_ref(800, 1'b0, 1'b0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule